// File: doc/BRIEF.md
# Variable-Page Fully Associative TLB

This block translates 64-bit virtual addresses through a fully associative array of translation entries. Each entry pairs a tag (virtual page base plus a 13-bit context) with a translation word. The translation word carries a valid flag, a privileged-only flag, a writable flag, a page frame, and its own page-size code: 8 KB, 64 KB, 512 KB or 4 MB. The size code sets how many low address bits the compare ignores and how many come through unchanged into the physical address.

A lookup gives an address, an access kind (read, write or instruction fetch) and a user-mode flag. It is checked against the current context. The result is one of three outcomes. The first is a translated address with its permissions. The second is a miss, when no entry matches. The third is a protection fault, when an entry matches but the access breaks its rules. Faults update a sticky fault status register, which also records an overflow when a second fault arrives before software has read it. Data-side faults also latch the faulting address. With translation turned off, addresses pass through unchanged. Entries are loaded one at a time through a write port. Choosing which entry to replace, and refilling it, belong to the surrounding logic.

Requests arrive on a valid/ready channel and results leave on a valid/ready channel one cycle later. A result stays stable while the consumer holds `rsp_ready` low. During that time `req_ready` is low, so at most one result is ever pending. The context, enable, entry write and status read pins are plain control signals.

Top module: `vtlb_top`

## Requirements
- R1: Translation-word bits 62:61 give the page size (0: 8 KB, 1: 64 KB, 2: 512 KB, 3: 4 MB). An entry's address compare ignores virtual address bits below bit 13, 16, 19 or 22 respectively, and it matches the tag with the tag's bits 12:0 treated as zero.
- R2: An entry matches only when tag bits 12:0 equal `cur_ctx`.
- R3: When several entries match, the entry with the lowest index decides the result.
- R4: A matching entry faults when its bit 63 (valid) is 0, when its bit 2 (privileged) is 1 and `req_user` is 1, or when the access is a write (`req_acc` = 1) and its bit 1 (writable) is 0. A fetch (`req_acc` = 2) never takes the write check. Any other code is a read.
- R5: Exactly one of `rsp_ok`, `rsp_miss`, `rsp_fault` is high with each result. A miss means no entry matched.
- R6: On a translated result, `rsp_pa` bits 40:12 take the frame bits of the translation word where the size mask is set and the virtual bits where it is clear. Bits 11:0 come from the virtual address, and bits 63:41 are zero.
- R7: `rsp_perm` (bit 0 read, bit 1 write, bit 2 execute) is read plus write-if-writable for data accesses and execute for fetches. It is zero on a miss or a fault.
- R8: With `mmu_en` low, every request gives `rsp_ok` with `rsp_pa` equal to `req_va`. The permissions are read+write for data accesses and execute for fetches.
- R9: On a fault, `fsr` first becomes 2 if it was nonzero. It then ORs in `req_user` at bit 3, the write flag at bit 2 and 1 at bit 0.
- R10: A data-access fault loads `far` with the virtual address. Fetch faults, misses and translated accesses leave `far` unchanged.
- R11: A cycle with `fsr_rd` high clears `fsr` to zero. A fault accepted in the same cycle is recorded on a zero base, with no overflow.
- R12: A result appears one cycle after its request is accepted. It stays unchanged while `rsp_ready` is low, and `req_ready` is low during that time.
- R13: An entry written through the write port is used by every lookup accepted from the next cycle on. After reset all entries are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mmu_en | input | 1 | Translation enable; low means pass-through |
| cur_ctx | input | 13 | Current address-space context |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be accepted |
| req_va | input | 64 | Virtual address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| req_user | input | 1 | Access comes from user mode |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Result consumer ready |
| rsp_ok | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No entry matched |
| rsp_fault | output | 1 | Protection fault |
| rsp_pa | output | 64 | Physical address |
| rsp_perm | output | 3 | Permissions: bit 0 read, bit 1 write, bit 2 execute |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 6 | Entry index to write |
| wr_tag | input | 64 | Tag value to write |
| wr_tte | input | 64 | Translation word to write |
| fsr_rd | input | 1 | Status read strobe; clears the status register |
| fsr | output | 4 | Fault status register |
| far | output | 64 | Fault address register |

## Verification
Directed entries of each page size are probed just inside and just outside their page boundary. This shows whether each size code picks the right compare mask and splits frame bits from offset bits correctly. Overlapping entries with different frames separate lowest-index priority from any other choice. Context mismatches separate a miss from a fault. Privileged, read-only and invalid entries are each hit with read, write and fetch accesses from both modes, which isolates each fault condition and the fetch exemption. Back-to-back faults with and without a status read between them, plus one read that lands together with a fault, tell overflow marking apart from a clean record. A long run of seeded random entries and lookups, mixing near-hit and arbitrary addresses and contexts, with occasional pass-through and status reads, then covers the combinations the directed cases miss.

// File: rtl/vtlb_pkg.sv
package vtlb_pkg;
  localparam int VA_W      = 64;
  localparam int CTX_W     = 13;
  localparam int PG_LO     = 13;
  localparam int PA_LO     = 12;
  localparam int PA_HI     = 40;
  localparam int TTE_VALID = 63;
  localparam int TTE_SZ_HI = 62;
  localparam int TTE_SZ_LO = 61;
  localparam int TTE_PRIV  = 2;
  localparam int TTE_WR    = 1;
  localparam int FSR_W     = 4;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  localparam logic [2:0] PERM_R = 3'b001;
  localparam logic [2:0] PERM_W = 3'b010;
  localparam logic [2:0] PERM_X = 3'b100;

  // Frame-select mask: ones where the page base lives.
  function automatic logic [VA_W-1:0] size_mask(input logic [1:0] sz);
    logic [VA_W-1:0] m;
    case (sz)
      2'd0:    m = {{(VA_W-13){1'b1}}, 13'b0};
      2'd1:    m = {{(VA_W-16){1'b1}}, 16'b0};
      2'd2:    m = {{(VA_W-19){1'b1}}, 19'b0};
      default: m = {{(VA_W-22){1'b1}}, 22'b0};
    endcase
    return m;
  endfunction
endpackage

// File: rtl/vtlb_match.sv
module vtlb_match
  import vtlb_pkg::*;
#(
  parameter int ENTRIES = 64
) (
  input  logic [VA_W-1:0]  tags [ENTRIES],
  input  logic [VA_W-1:0]  ttes [ENTRIES],
  input  logic [VA_W-1:0]  va,
  input  logic [CTX_W-1:0] ctx,
  output logic [ENTRIES-1:0] hit
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic [VA_W-1:0] msk;
    logic            ctx_eq;
    logic            va_eq;
    assign msk    = size_mask(ttes[g][TTE_SZ_HI:TTE_SZ_LO]);
    assign ctx_eq = (tags[g][CTX_W-1:0] == ctx);
    assign va_eq  = ((va & msk) == {tags[g][VA_W-1:PG_LO], {PG_LO{1'b0}}});
    assign hit[g] = ctx_eq && va_eq;
  end
endmodule

// File: rtl/vtlb_prio.sv
module vtlb_prio #(
  parameter int N  = 64,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  assign any = |vec;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/vtlb_fault_regs.sv
module vtlb_fault_regs
  import vtlb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fault_ev,
  input  logic             is_data,
  input  logic             is_user,
  input  logic             is_write,
  input  logic [VA_W-1:0]  va,
  input  logic             rd_clr,
  output logic [FSR_W-1:0] fsr,
  output logic [VA_W-1:0]  far
);
  logic [FSR_W-1:0] base;
  logic [FSR_W-1:0] seed;

  assign base = rd_clr ? '0 : fsr;
  assign seed = (base != '0) ? FSR_W'(2) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsr <= '0;
      far <= '0;
    end else begin
      if (fault_ev) begin
        fsr <= seed | {is_user, is_write, 1'b0, 1'b1};
        if (is_data) far <= va;
      end else if (rd_clr) begin
        fsr <= '0;
      end
    end
  end
endmodule

// File: rtl/vtlb_top.sv
module vtlb_top
  import vtlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mmu_en,
  input  logic [CTX_W-1:0]   cur_ctx,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_va,
  input  logic [1:0]         req_acc,
  input  logic               req_user,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic               rsp_ok,
  output logic               rsp_miss,
  output logic               rsp_fault,
  output logic [VA_W-1:0]    rsp_pa,
  output logic [2:0]         rsp_perm,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [VA_W-1:0]    wr_tag,
  input  logic [VA_W-1:0]    wr_tte,
  input  logic               fsr_rd,
  output logic [FSR_W-1:0]   fsr,
  output logic [VA_W-1:0]    far
);
  localparam int FRAME_W = PA_HI - PA_LO + 1;

  logic [VA_W-1:0] tag_q [ENTRIES];
  logic [VA_W-1:0] tte_q [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i] <= '0;
        tte_q[i] <= '0;
      end
    end else if (wr_en) begin
      tag_q[wr_idx] <= wr_tag;
      tte_q[wr_idx] <= wr_tte;
    end
  end

  logic [ENTRIES-1:0] hit_vec;
  logic               any_hit;
  logic [IDX_W-1:0]   sel_idx;

  vtlb_match #(.ENTRIES(ENTRIES)) i_match (
    .tags (tag_q),
    .ttes (tte_q),
    .va   (req_va),
    .ctx  (cur_ctx),
    .hit  (hit_vec)
  );

  vtlb_prio #(.N(ENTRIES), .IW(IDX_W)) i_prio (
    .vec (hit_vec),
    .any (any_hit),
    .idx (sel_idx)
  );

  logic [VA_W-1:0] sel_tte;
  logic [VA_W-1:0] sel_msk;
  logic [VA_W-1:0] page_pa;
  logic            is_fetch;
  logic            is_write;
  logic            bad;
  logic            fire;

  assign sel_tte  = tte_q[sel_idx];
  assign sel_msk  = size_mask(sel_tte[TTE_SZ_HI:TTE_SZ_LO]);
  assign page_pa  = (sel_tte & sel_msk) | (req_va & ~sel_msk);
  assign is_fetch = (req_acc == ACC_FETCH);
  assign is_write = (req_acc == ACC_WRITE);
  assign bad      = !sel_tte[TTE_VALID]
                  || (sel_tte[TTE_PRIV] && req_user)
                  || (is_write && !sel_tte[TTE_WR]);
  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;

  logic            n_ok, n_miss, n_fault;
  logic [VA_W-1:0] n_pa;
  logic [2:0]      n_perm;

  always_comb begin
    n_ok    = 1'b0;
    n_miss  = 1'b0;
    n_fault = 1'b0;
    n_pa    = '0;
    n_perm  = '0;
    if (!mmu_en) begin
      n_ok   = 1'b1;
      n_pa   = req_va;
      n_perm = is_fetch ? PERM_X : (PERM_R | PERM_W);
    end else if (!any_hit) begin
      n_miss = 1'b1;
    end else if (bad) begin
      n_fault = 1'b1;
    end else begin
      n_ok = 1'b1;
      n_pa = {{(VA_W-PA_HI-1){1'b0}}, page_pa[PA_HI:PA_LO], req_va[PA_LO-1:0]};
      if (is_fetch) n_perm = PERM_X;
      else          n_perm = PERM_R | (sel_tte[TTE_WR] ? PERM_W : 3'b000);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_pa    <= '0;
      rsp_perm  <= '0;
    end else if (req_ready) begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_ok    <= n_ok;
        rsp_miss  <= n_miss;
        rsp_fault <= n_fault;
        rsp_pa    <= n_pa;
        rsp_perm  <= n_perm;
      end
    end
  end

  logic [FRAME_W-1:0] unused_frame;
  assign unused_frame = '0;

  vtlb_fault_regs i_fregs (
    .clk      (clk),
    .rst_n    (rst_n),
    .fault_ev (fire && n_fault),
    .is_data  (!is_fetch),
    .is_user  (req_user),
    .is_write (is_write),
    .va       (req_va),
    .rd_clr   (fsr_rd),
    .fsr      (fsr),
    .far      (far)
  );
endmodule

// File: rtl/vtlb_checker.sv
module vtlb_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        mmu_en,
  input logic        req_valid,
  input logic        req_ready,
  input logic [63:0] req_va,
  input logic [1:0]  req_acc,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic        rsp_ok,
  input logic        rsp_miss,
  input logic        rsp_fault,
  input logic [63:0] rsp_pa,
  input logic        fsr_rd,
  input logic [3:0]  fsr,
  input logic [63:0] far
);
  p_one_outcome_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_ok, rsp_miss, rsp_fault}) == 1);

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pa)
                                   && $stable({rsp_ok, rsp_miss, rsp_fault})));

  p_stall_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  p_passthru_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !mmu_en) |=> (rsp_ok && rsp_pa == $past(req_va)));

  p_fsr_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault && $past(req_valid && req_ready)) |-> fsr[0]);

  p_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault && $past(req_valid && req_ready && fsr != 4'd0 && !fsr_rd))
      |-> fsr[1]);

  p_far_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault && $past(req_valid && req_ready && req_acc != 2'd2))
      |-> far == $past(req_va));

  p_rdclr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fsr_rd && !(req_valid && req_ready)) |=> fsr == 4'd0);
endmodule

bind vtlb_top vtlb_checker i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mmu_en    (mmu_en),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_va    (req_va),
  .req_acc   (req_acc),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_ok    (rsp_ok),
  .rsp_miss  (rsp_miss),
  .rsp_fault (rsp_fault),
  .rsp_pa    (rsp_pa),
  .fsr_rd    (fsr_rd),
  .fsr       (fsr),
  .far       (far)
);

// File: tb/test_vtlb_top.sv
module test_vtlb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NENT       = 64;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mmu_en = 1'b1;
  logic [12:0] cur_ctx = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_va = '0;
  logic [1:0]  req_acc = '0;
  logic        req_user = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_ok, rsp_miss, rsp_fault;
  logic [63:0] rsp_pa;
  logic [2:0]  rsp_perm;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_idx = '0;
  logic [63:0] wr_tag = '0;
  logic [63:0] wr_tte = '0;
  logic        fsr_rd = 1'b0;
  logic [3:0]  fsr;
  logic [63:0] far;

  always #(CLK_PERIOD/2) clk = ~clk;

  vtlb_top i_vtlb_top (.*);

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [63:0] m_tag [NENT];
  logic [63:0] m_tte [NENT];
  logic [3:0]  m_fsr = '0;
  logic [63:0] m_far = '0;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] bmask(input logic [1:0] sz);
    int sh;
    sh = 13 + 3 * int'(sz);
    return ~((64'd1 << sh) - 64'd1);
  endfunction

  task automatic model(input logic [63:0] va, input logic [1:0] acc, input logic user,
                       input logic [12:0] ctx, input logic en,
                       output logic [2:0] eout, output logic [63:0] epa,
                       output logic [2:0] eperm);
    int hit;
    logic [63:0] m, t;
    hit = -1;
    eout = 3'b000; epa = '0; eperm = '0;
    for (int i = 0; i < NENT; i++) begin
      m = bmask(m_tte[i][62:61]);
      if (hit < 0 && m_tag[i][12:0] == ctx && (va & m) == (m_tag[i] & ~64'h1fff))
        hit = i;
    end
    if (!en) begin
      eout = 3'b100; epa = va;
      eperm = (acc == 2'd2) ? 3'b100 : 3'b011;
    end else if (hit < 0) begin
      eout = 3'b010;
    end else begin
      t = m_tte[hit];
      m = bmask(t[62:61]);
      if (!t[63] || (t[2] && user) || (acc == 2'd1 && !t[1])) begin
        eout = 3'b001;
      end else begin
        eout = 3'b100;
        epa = (((t & m) | (va & ~m)) & 64'h1FF_FFFF_F000) | (va & 64'hFFF);
        eperm = (acc == 2'd2) ? 3'b100 : {1'b0, t[1], 1'b1};
      end
    end
  endtask

  task automatic put_entry(input int idx, input logic [63:0] tag, input logic [63:0] tte);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 6'(idx); wr_tag = tag; wr_tte = tte;
    @(posedge clk);
    m_tag[idx] = tag; m_tte[idx] = tte;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic lookup(input string req, input logic [63:0] va, input logic [1:0] acc,
                        input logic user, input logic [12:0] ctx, input logic en,
                        input logic rd);
    logic [2:0] eout, eperm;
    logic [63:0] epa;
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_acc = acc; req_user = user;
    cur_ctx = ctx; mmu_en = en; fsr_rd = rd;
    model(va, acc, user, ctx, en, eout, epa, eperm);
    @(posedge clk);
    if (rd) m_fsr = '0;
    if (eout == 3'b001) begin
      m_fsr = ((m_fsr != 0) ? 4'd2 : 4'd0) | {user, acc == 2'd1, 1'b0, 1'b1};
      if (acc != 2'd2) m_far = va;
    end
    @(negedge clk);
    req_valid = 1'b0; fsr_rd = 1'b0;
    chk(req, "valid", 64'(rsp_valid), 64'd1);
    chk(req, "outcome", 64'({rsp_ok, rsp_miss, rsp_fault}), 64'(eout));
    chk(req, "pa", rsp_pa, epa);
    chk(req, "perm", 64'(rsp_perm), 64'(eperm));
    chk(req, "fsr", 64'(fsr), 64'(m_fsr));
    chk(req, "far", far, m_far);
  endtask

  task automatic read_fsr();
    @(negedge clk);
    fsr_rd = 1'b1;
    @(posedge clk);
    m_fsr = '0;
    @(negedge clk);
    fsr_rd = 1'b0;
    chk("R11", "fsr after read", 64'(fsr), 64'd0);
  endtask

  localparam logic [63:0] V  = 64'h8000_0000_0000_0000;
  localparam logic [63:0] PR = 64'h4;
  localparam logic [63:0] WR = 64'h2;

  initial begin
    logic [63:0] base, pa_frame;
    logic [63:0] t, g, va, m;
    int j;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NENT; i++) begin m_tag[i] = '0; m_tte[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R12", "reset rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R12", "reset req_ready", 64'(req_ready), 64'd1);
    chk("R9", "reset fsr", 64'(fsr), 64'd0);
    chk("R10", "reset far", far, 64'd0);

    // R13: zeroed entries match context 0, page 0, and are invalid -> fault
    lookup("R13", 64'h1234, 2'd0, 1'b0, 13'd0, 1'b1, 1'b0);
    read_fsr();

    // R1/R6: one entry per page size, probe inside and just past the page
    for (int s = 0; s < 4; s++) begin
      base = 64'h0000_1234_5600_0000 + (64'(s) << 24);
      pa_frame = 64'h0155_5555_5000_0000 >> 8;
      t = V | WR | (64'(s) << 61) | (pa_frame & 64'h1FF_FFFF_E000);
      put_entry(10 + s, base | 64'd7, t);
      m = bmask(2'(s));
      lookup("R1", base | (~m & 64'h3F_FFFF & 64'hFFFF_FFFF_FFFF_FABC), 2'd0, 1'b0, 13'd7, 1'b1, 1'b0);
      lookup("R6", base | (~m), 2'd1, 1'b0, 13'd7, 1'b1, 1'b0);
      lookup("R1", base + (~m + 64'd1), 2'd0, 1'b0, 13'd7, 1'b1, 1'b0);
    end

    // R2: context mismatch is a miss
    lookup("R2", 64'h0000_1234_5600_0100, 2'd0, 1'b0, 13'd8, 1'b1, 1'b0);
    lookup("R5", 64'hFFFF_0000_0000_0000, 2'd2, 1'b1, 13'd7, 1'b1, 1'b0);

    // R3: overlapping entries, lower index wins
    put_entry(40, 64'h0000_0077_0000_0003, V | WR | 64'h0000_00AA_0000_0000);
    put_entry(20, 64'h0000_0077_0000_0003, V | 64'h0000_00BB_0000_0000);
    lookup("R3", 64'h0000_0077_0000_0040, 2'd0, 1'b0, 13'd3, 1'b1, 1'b0);
    lookup("R3", 64'h0000_0077_0000_0040, 2'd1, 1'b0, 13'd3, 1'b1, 1'b0);
    read_fsr();

    // R4/R7: privileged, read-only, invalid
    put_entry(30, 64'h0000_0088_0000_0005, V | PR | 64'h0000_0011_0000_0000);
    lookup("R4", 64'h0000_0088_0000_0010, 2'd0, 1'b1, 13'd5, 1'b1, 1'b0);
    lookup("R7", 64'h0000_0088_0000_0010, 2'd2, 1'b0, 13'd5, 1'b1, 1'b0);
    lookup("R9", 64'h0000_0088_0000_0020, 2'd1, 1'b0, 13'd5, 1'b1, 1'b0);
    lookup("R4", 64'h0000_0088_0000_0030, 2'd2, 1'b1, 13'd5, 1'b1, 1'b0);
    chk("R10", "far kept after fetch fault", far, 64'h0000_0088_0000_0020);
    read_fsr();
    put_entry(31, 64'h0000_0099_0000_0005, 64'h0000_0022_0000_0002);
    lookup("R4", 64'h0000_0099_0000_0010, 2'd2, 1'b0, 13'd5, 1'b1, 1'b0);
    // R11: read in the same cycle as a fault
    lookup("R11", 64'h0000_0099_0000_0018, 2'd1, 1'b1, 13'd5, 1'b1, 1'b1);
    chk("R11", "fsr clean record", 64'(fsr), 64'hD);
    read_fsr();

    // R8: pass-through
    lookup("R8", 64'hDEAD_BEEF_CAFE_1234, 2'd1, 1'b1, 13'd9, 1'b0, 1'b0);
    lookup("R8", 64'h0000_0088_0000_0010, 2'd2, 1'b1, 13'd5, 1'b0, 1'b0);

    // R12: back-pressure
    lookup("R12", 64'h0000_0077_0000_0044, 2'd0, 1'b0, 13'd3, 1'b1, 1'b0);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_va = 64'h5555;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R12", "held valid", 64'(rsp_valid), 64'd1);
    chk("R12", "stalled ready", 64'(req_ready), 64'd0);
    chk("R12", "held pa", rsp_pa, 64'h0000_00BB_0000_0044);
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R12", "drained", 64'(rsp_valid), 64'd0);

    // Random phase
    for (int i = 0; i < NENT; i++) begin
      logic [1:0] sz;
      sz = 2'($urandom_range(0, 3));
      g = {$urandom, $urandom} & bmask(sz) & 64'h0000_0FFF_FFFF_FFFF;
      g = g | 64'($urandom_range(0, 3));
      t = {$urandom, $urandom};
      t[63] = ($urandom_range(0, 7) != 0);
      t[62:61] = sz;
      put_entry(i, g, t);
    end
    for (int k = 0; k < 1500; k++) begin
      logic [12:0] c;
      j = $urandom_range(0, NENT - 1);
      m = bmask(m_tte[j][62:61]);
      if ($urandom_range(0, 3) == 0) va = {$urandom, $urandom};
      else va = (m_tag[j] & ~64'h1fff) | ({$urandom, $urandom} & ~m);
      c = ($urandom_range(0, 7) == 0) ? 13'($urandom) : m_tag[j][12:0];
      lookup("R4", va, 2'($urandom_range(0, 2)), 1'($urandom), c,
             ($urandom_range(0, 19) != 0), ($urandom_range(0, 9) == 0));
    end

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL R12 watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule